// File: doc/BRIEF.md
# Delay-Line Load Control Loop

This block is the digital half of a delay-locked loop. It turns the early/late decisions of a two-state phase detector into a thermometer-coded control word. Each bit of the word switches one load element of a delay line. The detector bit arrives asynchronously, so it is first passed through a flop synchronizer. Only then does it steer the word.

The word is held in a bidirectional shift register. An "up" decision pushes a 1 in at the low end, which lengthens the run of ones. A "down" decision pushes a 0 in at the high end. The register moves only on a slow update tick, which is the overflow of a free-running prescaler counter. This tick sets the loop bandwidth. The update enable and the direction are pipelined one register per stage. Stage i therefore updates i cycles after stage 0. Each stage reads the one-cycle-delayed value of its lower neighbour, so the word stays a thermometer code while an update ripples through it.

Two status flags come with the word. The saturation flag reports that the detector is pushing beyond either end of the range. The lock flag reports that the decisions have dithered back and forth for a programmable number of consecutive ticks.

Top module: `dlc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the word is loaded with half scale: bits [N/2-1:0] are ones and the rest are zeros. At the same edge, `locked`, `saturated`, the prescaler and the pipeline stages are cleared.
- R2: `pd_up_raw` passes through two synchronizer flops before use. A tick takes the value the input had before the edge two cycles ahead of that tick. A later change is ignored by that tick.
- R3: The prescaler counts from 0 after reset and raises one tick per 2^PRESC_W cycles. The first tick is active in the 2^PRESC_W-th cycle after reset is released. Bit 0 of the word changes only at the edge that ends a tick cycle.
- R4: The word encoding is the number of ones, with ones packed from bit 0. Direction value 1 (up) adds one to this count per tick. Direction value 0 (down) removes one per tick.
- R5: Stage i of the word takes its new value i clock edges after stage 0 does. Stage 0 updates at the edge that ends the tick cycle.
- R6: The word is a valid thermometer code in every cycle, including while an update is rippling through the stages.
- R7: On a tick, `saturated` is set if the word is all ones with up requested, or all zeros with down requested. In that case the word stays unchanged. Any other tick clears the flag.
- R8: A tick whose direction differs from the previous tick's direction increments an alternation count. A tick with the same direction resets the count to 0, and so does the first tick after reset. `locked` is set on a tick when the count is at least `lock_len` (a value of 0 therefore locks on any tick). Otherwise that tick clears `locked`.
- R9: Between ticks, the word and both flags ignore any activity on `pd_up_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_up_raw | input | 1 | Asynchronous phase detector decision, 1 = add load |
| lock_len | input | LOCK_W | Number of consecutive alternating ticks needed for lock |
| ctrl_word | output | THERM_N | Thermometer load-control word |
| locked | output | 1 | Loop dithering around its target |
| saturated | output | 1 | Detector pushing beyond an end of the range |

## Verification
The saturation flag and the lock flag are both decided on the same tick. One tick can set saturation and drop lock at once. The bench provokes this case as follows. It climbs to full scale, steps down once and back up so that the alternation count reaches a lock length of two, and then requests up again at full scale. After that tick it requires `saturated` to be 1, `locked` to be 0 and the word to stay all ones. Before that tick it requires the opposite flag pair.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/dlc_sync.sv
module dlc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q = s_q.sh[STAGES-1];

endmodule

// File: rtl/dlc_prescaler.sv
module dlc_prescaler #(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // overflow of the free-running count gates the loop
    assign tick = &s_q.cnt;

endmodule

// File: rtl/dlc_therm.sv
module dlc_therm
    import dlc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  dir_e         dir,
    output logic [N-1:0] word
);

    localparam logic [N-1:0] HALF = {{(N - N/2){1'b0}}, {(N/2){1'b1}}};

    typedef struct packed {
        logic [N-1:0] word;  // live stage outputs
        logic [N-1:0] dly;   // stage outputs one cycle late
        logic [N-1:1] en;    // enable wavefront per stage
        logic [N-1:1] up;    // direction travelling with it
    } therm_t;

    therm_t s_d, s_q;

    logic [N-1:0] en_s;
    logic [N-1:0] up_s;
    logic [N-1:0] from_lo;
    logic [N-1:0] from_hi;

    assign en_s[0]    = tick;
    assign up_s[0]    = (dir == DIR_UP);
    assign from_lo[0] = 1'b1;          // ones enter at the low end
    assign from_hi[N-1] = 1'b0;        // zeros enter at the high end

    for (genvar g = 1; g < N; g++) begin : g_stage_ctl
        assign en_s[g]    = s_q.en[g];
        assign up_s[g]    = s_q.up[g];
        assign from_lo[g] = s_q.dly[g-1];
    end

    for (genvar g = 0; g < N - 1; g++) begin : g_stage_hi
        assign from_hi[g] = s_q.word[g+1];
    end

    always_comb begin
        s_d     = s_q;
        s_d.dly = s_q.word;
        for (int i = 1; i < N; i++) begin
            s_d.en[i] = en_s[i-1];
            s_d.up[i] = up_s[i-1];
        end
        for (int i = 0; i < N; i++) begin
            if (en_s[i]) begin
                s_d.word[i] = up_s[i] ? from_lo[i] : from_hi[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.word <= HALF;
            s_q.dly  <= HALF;
            s_q.en   <= '0;
            s_q.up   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word = s_q.word;

endmodule

// File: rtl/dlc_monitor.sv
module dlc_monitor
    import dlc_pkg::*;
#(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  dir_e          dir,
    input  logic [N-1:0]  word,
    input  logic [LW-1:0] lock_len,
    output logic          locked,
    output logic          saturated
);

    localparam logic [LW-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic          have_prev;
        dir_e          prev;
        logic [LW-1:0] run;
        logic          lock;
        logic          sat;
    } mon_t;

    mon_t s_d, s_q;

    logic full;
    logic empty;
    logic alt;

    assign full  = &word;
    assign empty = ~|word;
    assign alt   = s_q.have_prev && (dir != s_q.prev);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (alt) s_d.run = (s_q.run == RUN_MAX) ? s_q.run : s_q.run + 1'b1;
            else     s_d.run = '0;
            s_d.lock      = (s_d.run >= lock_len);
            s_d.sat       = (full && dir == DIR_UP) || (empty && dir == DIR_DOWN);
            s_d.have_prev = 1'b1;
            s_d.prev      = dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{have_prev: 1'b0, prev: DIR_DOWN, run: '0, lock: 1'b0, sat: 1'b0};
        else     s_q <= s_d;
    end

    assign locked    = s_q.lock;
    assign saturated = s_q.sat;

endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
    import dlc_pkg::*;
#(
    parameter int THERM_N     = 16,
    parameter int PRESC_W     = 6,
    parameter int LOCK_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_up_raw,
    input  logic [LOCK_W-1:0]  lock_len,
    output logic [THERM_N-1:0] ctrl_word,
    output logic               locked,
    output logic               saturated
);

    logic dir_sync;
    logic tick;
    dir_e dir;

    dlc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pd_up_raw),
        .q   (dir_sync)
    );

    assign dir = dir_e'(dir_sync);

    dlc_prescaler #(.W(PRESC_W)) i_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dlc_therm #(.N(THERM_N)) i_therm (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .dir  (dir),
        .word (ctrl_word)
    );

    dlc_monitor #(.N(THERM_N), .LW(LOCK_W)) i_mon (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .dir       (dir),
        .word      (ctrl_word),
        .lock_len  (lock_len),
        .locked    (locked),
        .saturated (saturated)
    );

endmodule

// File: rtl/dlc_ctrl_chk.sv
module dlc_ctrl_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         raw,
    input logic         dir_sync,
    input logic         tick,
    input logic [N-1:0] word,
    input logic         locked,
    input logic         saturated
);

    localparam logic [N-1:0] HALF = {{(N - N/2){1'b0}}, {(N/2){1'b1}}};

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (word == HALF) && !locked && !saturated);

    p_sync_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (dir_sync == $past(raw, 2)));

    p_bit0_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> $stable(word[0]));

    p_thermo_code_r6: assert property (@(posedge clk) disable iff (rst)
        ((word & (word + 1'b1)) == '0));

    p_sat_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        saturated |-> ((&word) || (word == '0)));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> ($stable(locked) && $stable(saturated)));

endmodule

bind dlc_ctrl dlc_ctrl_chk #(.N(THERM_N)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .raw       (pd_up_raw),
    .dir_sync  (dir_sync),
    .tick      (tick),
    .word      (ctrl_word),
    .locked    (locked),
    .saturated (saturated)
);

// File: tb/test_dlc_ctrl.sv
module test_dlc_ctrl;

    localparam int N   = 16;
    localparam int PW  = 6;
    localparam int LW  = 4;
    localparam int PER = 1 << PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pd_up_raw = 1'b0;
    logic [LW-1:0] lock_len = '0;
    logic [N-1:0]  ctrl_word;
    logic          locked;
    logic          saturated;

    int n_run  = 0;
    int n_fail = 0;
    int edges  = 0;
    int exp_cnt;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    dlc_ctrl #(.THERM_N(N), .PRESC_W(PW), .LOCK_W(LW)) i_dlc_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pd_up_raw (pd_up_raw),
        .lock_len  (lock_len),
        .ctrl_word (ctrl_word),
        .locked    (locked),
        .saturated (saturated)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_cnt(input string req, input int exp);
        check($countones(ctrl_word) == exp && (ctrl_word & (ctrl_word + 1'b1)) == '0,
              req, $countones(ctrl_word), exp);
    endtask

    // advance to just after the edge at which the bench phase equals p
    task automatic goto(input int p);
        do begin
            @(posedge clk);
            #5;
        end while ((edges % PER) != p);
    endtask

    task automatic do_ticks(input logic up, input int n);
        pd_up_raw = up;
        for (int k = 0; k < n; k++) begin
            goto(40);
            exp_cnt = up ? (exp_cnt < N ? exp_cnt + 1 : N) : (exp_cnt > 0 ? exp_cnt - 1 : 0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        exp_cnt = N / 2;
        // R1 reset state
        check(ctrl_word == {{(N - N/2){1'b0}}, {(N/2){1'b1}}}, "R1 word", int'(ctrl_word), (1 << (N/2)) - 1);
        check(!locked && !saturated, "R1 flags", {locked, saturated}, 0);
        goto(40);
    endtask

    task automatic t_first_tick_ripple();
        do_reset();
        pd_up_raw = 1'b1;
        goto(PER - 1);
        check_cnt("R3 no change before first tick", N/2);
        goto(N/2 - 1);
        check_cnt("R5 stage not yet reached", N/2);
        goto(N/2);
        check_cnt("R5 stage updated on its edge", N/2 + 1);
        check(ctrl_word[N/2] == 1'b1, "R4 one enters from low side", ctrl_word[N/2], 1);
        goto(40);
        exp_cnt = N/2 + 1;
    endtask

    task automatic t_up_down();
        do_reset();
        do_ticks(1'b1, 3);
        check_cnt("R4 up by three", exp_cnt);
        do_ticks(1'b0, 5);
        check_cnt("R4 down by five", exp_cnt);
    endtask

    task automatic t_sync();
        do_reset();
        pd_up_raw = 1'b0;
        goto(PER - 2);
        pd_up_raw = 1'b1;          // too late for this tick
        goto(40);
        check_cnt("R2 late change ignored", N/2 - 1);
        goto(PER - 3);
        pd_up_raw = 1'b0;          // just in time for this tick
        goto(40);
        check_cnt("R2 timely change used", N/2 - 2);
    endtask

    task automatic t_ignore();
        logic [N-1:0] w0;
        logic         l0;
        logic         s0;
        do_reset();
        do_ticks(1'b1, 2);
        w0 = ctrl_word;
        l0 = locked;
        s0 = saturated;
        for (int k = 0; k < 8; k++) begin
            pd_up_raw = ~pd_up_raw;
            @(posedge clk);
            #5;
        end
        goto(55);
        check(ctrl_word == w0, "R9 word between ticks", int'(ctrl_word), int'(w0));
        check(locked == l0 && saturated == s0, "R9 flags between ticks", {locked, saturated}, {l0, s0});
        goto(40);
    endtask

    task automatic t_saturate();
        do_reset();
        do_ticks(1'b1, N/2);
        check_cnt("R4 reach full", N);
        check(!saturated, "R7 not yet saturated", saturated, 0);
        do_ticks(1'b1, 1);
        check_cnt("R7 word held at full", N);
        check(saturated, "R7 saturated high", saturated, 1);
        do_ticks(1'b0, 1);
        check(!saturated, "R7 cleared by reverse tick", saturated, 0);
        do_ticks(1'b0, N - 1);
        check_cnt("R4 reach empty", 0);
        check(!saturated, "R7 not saturated at arrival", saturated, 0);
        do_ticks(1'b0, 1);
        check_cnt("R7 word held at empty", 0);
        check(saturated, "R7 saturated low", saturated, 1);
        do_ticks(1'b1, 1);
        check_cnt("R4 leave empty", 1);
        check(!saturated, "R7 cleared leaving empty", saturated, 0);
    endtask

    task automatic t_lock();
        do_reset();
        lock_len = 4'd3;
        do_ticks(1'b1, 1);
        do_ticks(1'b0, 1);
        do_ticks(1'b1, 1);
        check(!locked, "R8 two alternations short", locked, 0);
        do_ticks(1'b0, 1);
        check(locked, "R8 lock after three alternations", locked, 1);
        check_cnt("R4 dither keeps centre", N/2);
        do_ticks(1'b0, 1);
        check(!locked, "R8 repeat direction drops lock", locked, 0);
        check_cnt("R4 after repeat", N/2 - 1);
    endtask

    task automatic t_sat_and_lock();
        do_reset();
        lock_len = 4'd2;
        do_ticks(1'b1, N/2);
        do_ticks(1'b0, 1);
        do_ticks(1'b1, 1);
        check(locked && !saturated, "R8 locked at top before push", {locked, saturated}, 2);
        do_ticks(1'b1, 1);
        check(!locked && saturated, "R7 R8 same-tick sat rise and lock fall", {locked, saturated}, 1);
        check_cnt("R7 word full", N);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_first_tick_ripple();
        t_up_down();
        t_sync();
        t_ignore();
        t_saturate();
        t_lock();
        t_sat_and_lock();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule